// File: doc/BRIEF.md
# Dual Interrupt Request Selector

This block raises two independent interrupt requests and merges them onto one request line to the host processor. Each request has a 2-bit source mode held in a write-only select word. The mode picks one of four causes: a change-of-state pulse from an external detector, a gated two-pin edge function, the falling edge of one pin, or a terminal pulse from a counter or timer. The detectors and counters are outside the block and deliver single-cycle pulses. The pins are asynchronous and are synchronized inside the block.

When its selected cause fires, a request becomes pending and stays pending. Software reads a status word to see which request is pending. It then writes any value to the clear address, which drops both pending flags. Further causes that arrive while a flag is already pending merge into that flag.

Top module: `irq_source_sel`

## Requirements
- R1: The select word sits at address 0x50 and is write-only, so a read there returns 0. Bits [1:0] hold the mode of request 0 and bits [3:2] hold the mode of request 1. After reset both modes are 00 and both pending flags are 0.
- R2: In mode 00, a pulse on `cos_evt[i]` sets pending flag i.
- R3: In mode 01, flag i is set by a synchronized falling edge of `pin_c3[i]` while `pin_c0[i]` is low, or by a rising edge of `pin_c0[i]` while `pin_c3[i]` is high. The levels used are the synchronized values after the edge. A rise of c0 and a fall of c3 in the same cycle sets nothing. Any other pin activity sets nothing.
- R4: In mode 10, a synchronized falling edge of `pin_c0[i]` sets flag i, and a rising edge does not.
- R5: In mode 11, a pulse on `cnt_evt[i]` sets flag i.
- R6: Causes that belong to a mode other than the selected one have no effect on the flag.
- R7: A pending flag stays set until a write of any data to address 0x54. That write clears both flags, unless a selected cause fires in the same cycle, in which case that flag stays set. A write to any other address does not clear.
- R8: A cause that arrives while its flag is pending is merged into the flag, so a single clear leaves the flag at 0.
- R9: `irq_host` is high exactly when at least one flag is pending. The status word at address 0x58 shows flag 0 in bit 0 and flag 1 in bit 1, with the other bits 0.
- R10: A pin change applied before clock edge k is visible in the flag after edge k+2 (two synchronizer stages plus the flag register), and not after edge k+1. Each pin edge yields a pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Register address, used for both write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| cos_evt | input | 2 | Change-of-state pulse per request |
| cnt_evt | input | 2 | Counter or timer terminal pulse per request |
| pin_c0 | input | 2 | Asynchronous pin C0 per request |
| pin_c3 | input | 2 | Asynchronous pin C3 per request |
| irq_host | output | 1 | Shared host interrupt line |

## Verification
The bench builds the block with its defaults: two requests, two synchronizer stages and 8-bit address and data. With these values every mode of both requests is reachable, and so is every mix of the two modes within one select word. The two-stage synchronizer lets the bench check the exact cycle in which a pin edge appears, and one cycle early. The directed part covers the gated two-pin function, including both edges landing in the same cycle, a clear that coincides with an event, merged events and a write to the wrong address.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    SRC_COS  = 2'b00,
    SRC_PAIR = 2'b01,
    SRC_FALL = 2'b10,
    SRC_CNT  = 2'b11
  } src_mode_e;

  // gated two-pin function evaluated on synchronized levels after the edge
  function automatic logic pair_trigger(input logic c0_lvl, input logic c0_rise,
                                        input logic c3_lvl, input logic c3_fall);
    return (c3_fall & ~c0_lvl) | (c0_rise & c3_lvl);
  endfunction

  function automatic logic pick_source(input src_mode_e mode, input logic cos_hit,
                                       input logic pair_hit, input logic fall_hit,
                                       input logic cnt_hit);
    logic hit;
    unique case (mode)
      SRC_COS:  hit = cos_hit;
      SRC_PAIR: hit = pair_hit;
      SRC_FALL: hit = fall_hit;
      default:  hit = cnt_hit;
    endcase
    return hit;
  endfunction

  // an event in the clear cycle wins over the clear
  function automatic logic next_pending(input logic pend, input logic trig, input logic clr);
    return (pend & ~clr) | trig;
  endfunction

endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl  = sync_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/irq_req_chan.sv
module irq_req_chan
  import irq_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  src_mode_e mode,
  input  logic      cos_hit,
  input  logic      cnt_hit,
  input  logic      c0_lvl,
  input  logic      c0_rise,
  input  logic      c0_fall,
  input  logic      c3_lvl,
  input  logic      c3_fall,
  input  logic      clr,
  output logic      pair_hit,
  output logic      trig,
  output logic      pending
);
  assign pair_hit = pair_trigger(c0_lvl, c0_rise, c3_lvl, c3_fall);
  assign trig     = pick_source(mode, cos_hit, pair_hit, c0_fall, cnt_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= next_pending(pending, trig, clr);
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NREQ   = 2,
  parameter logic [ADDR_W-1:0] SEL_ADR  = 'h50,
  parameter logic [ADDR_W-1:0] CLR_ADR  = 'h54,
  parameter logic [ADDR_W-1:0] STAT_ADR = 'h58
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NREQ-1:0]   pend,
  output logic [2*NREQ-1:0] sel_word,
  output logic              clr_stb,
  output logic [DATA_W-1:0] rdata
);
  localparam int SEL_W = 2 * NREQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sel_word <= '0;
    else if (wr_en && addr == SEL_ADR)   sel_word <= wdata[SEL_W-1:0];
  end

  assign clr_stb = wr_en && (addr == CLR_ADR);

  always_comb begin
    rdata = '0;
    if (addr == STAT_ADR) rdata[NREQ-1:0] = pend;
  end
endmodule

// File: rtl/irq_source_sel.sv
module irq_source_sel
  import irq_sel_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int NUM_REQ     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_REQ-1:0] cos_evt,
  input  logic [NUM_REQ-1:0] cnt_evt,
  input  logic [NUM_REQ-1:0] pin_c0,
  input  logic [NUM_REQ-1:0] pin_c3,
  output logic               irq_host
);
  localparam int SEL_W = 2 * NUM_REQ;

  logic [SEL_W-1:0]   sel_word;
  logic               clr_stb;
  logic [NUM_REQ-1:0] pend_vec, trig_vec, pair_vec;
  logic [NUM_REQ-1:0] c0_lvl, c0_rise, c0_fall;
  logic [NUM_REQ-1:0] c3_lvl, c3_rise, c3_fall;
  logic               unused_c3_rise;

  assign unused_c3_rise = ^c3_rise;

  irq_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREQ(NUM_REQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend(pend_vec), .sel_word(sel_word), .clr_stb(clr_stb), .rdata(rdata)
  );

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    irq_pin_edge #(.STAGES(SYNC_STAGES)) u_c0 (
      .clk(clk), .rst_n(rst_n), .pin(pin_c0[i]),
      .lvl(c0_lvl[i]), .rise(c0_rise[i]), .fall(c0_fall[i])
    );
    irq_pin_edge #(.STAGES(SYNC_STAGES)) u_c3 (
      .clk(clk), .rst_n(rst_n), .pin(pin_c3[i]),
      .lvl(c3_lvl[i]), .rise(c3_rise[i]), .fall(c3_fall[i])
    );
    irq_req_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .mode(src_mode_e'(sel_word[2*i +: 2])),
      .cos_hit(cos_evt[i]), .cnt_hit(cnt_evt[i]),
      .c0_lvl(c0_lvl[i]), .c0_rise(c0_rise[i]), .c0_fall(c0_fall[i]),
      .c3_lvl(c3_lvl[i]), .c3_fall(c3_fall[i]),
      .clr(clr_stb), .pair_hit(pair_vec[i]), .trig(trig_vec[i]),
      .pending(pend_vec[i])
    );
  end

  assign irq_host = |pend_vec;
endmodule

// File: rtl/irq_source_sel_chk.sv
module irq_source_sel_chk #(
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr_stb,
  input logic         irq_host,
  input logic [N-1:0] pend_vec,
  input logic [N-1:0] trig_vec,
  input logic [N-1:0] pair_vec,
  input logic [N-1:0] c0_lvl,
  input logic [N-1:0] c0_rise,
  input logic [N-1:0] c3_lvl,
  input logic [N-1:0] c3_fall
);
  AST_PAIR_C0_GATE: assert property (@(posedge clk) disable iff (!rst_n) ((pair_vec & c0_lvl & ~c0_rise) == '0)); // R3
  AST_PAIR_C3_GATE: assert property (@(posedge clk) disable iff (!rst_n) ((pair_vec & ~c3_lvl & ~c3_fall) == '0)); // R3
  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (c0_rise != '0) |=> ((c0_rise & $past(c0_rise)) == '0)); // R10
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (clr_stb && trig_vec == '0) |=> (pend_vec == '0)); // R7
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!clr_stb) |=> ((pend_vec & $past(pend_vec)) == $past(pend_vec))); // R8
  AST_SET_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((pend_vec & ~$past(pend_vec) & ~$past(trig_vec)) == '0)); // R6
  AST_HOST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_host) |-> ($past(trig_vec) != '0)); // R9
endmodule

bind irq_source_sel irq_source_sel_chk #(.N(NUM_REQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_stb(clr_stb), .irq_host(irq_host),
  .pend_vec(pend_vec), .trig_vec(trig_vec), .pair_vec(pair_vec),
  .c0_lvl(c0_lvl), .c0_rise(c0_rise), .c3_lvl(c3_lvl), .c3_fall(c3_fall)
);

// File: tb/sim_irq_source_sel.sv
module sim_irq_source_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h58;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] cos_evt = 2'b00, cnt_evt = 2'b00, pin_c0 = 2'b00, pin_c3 = 2'b00;
  logic       irq_host;
  int total = 0, bad = 0;

  localparam logic [7:0] A_SEL = 8'h50, A_CLR = 8'h54, A_STAT = 8'h58;

  // {sel[3:0], cos[1:0], cnt[1:0], expected flags[1:0]}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    {4'b0000, 2'b01, 2'b00, 2'b01},  // R2 req0
    {4'b0000, 2'b10, 2'b00, 2'b10},  // R2 req1
    {4'b0000, 2'b00, 2'b11, 2'b00},  // R6 counters ignored in mode 00
    {4'b1111, 2'b00, 2'b01, 2'b01},  // R5 req0
    {4'b1111, 2'b00, 2'b10, 2'b10},  // R5 req1
    {4'b1111, 2'b11, 2'b00, 2'b00},  // R6 cos ignored in mode 11
    {4'b0011, 2'b11, 2'b11, 2'b11},  // R5/R2 mixed
    {4'b1100, 2'b01, 2'b01, 2'b01},  // R2/R6 mixed
    {4'b0101, 2'b11, 2'b11, 2'b00},  // R6 pulses ignored in mode 01
    {4'b1010, 2'b11, 2'b11, 2'b00}   // R6 pulses ignored in mode 10
  };

  irq_source_sel u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cos_evt(cos_evt), .cnt_evt(cnt_evt),
    .pin_c0(pin_c0), .pin_c3(pin_c3), .irq_host(irq_host)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req, input logic [1:0] exp);
    addr = A_STAT;
    #1;
    check(req, rdata, {6'b0, exp});
    check({req, " host"}, {7'b0, irq_host}, {7'b0, |exp});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = A_STAT;
  endtask

  task automatic pulse(input logic [1:0] cos, input logic [1:0] cnt);
    @(negedge clk);
    cos_evt = cos; cnt_evt = cnt;
    @(negedge clk);
    cos_evt = 2'b00; cnt_evt = 2'b00;
  endtask

  task automatic set_pins_quiet(input logic [1:0] c0, input logic [1:0] c3);
    @(negedge clk);
    pin_c0 = c0; pin_c3 = c3;
    repeat (5) @(negedge clk);
    wr(A_CLR, 8'h00);
  endtask

  // drive pins, then check one cycle early and at the expected cycle
  task automatic pin_step(input string req, input logic [1:0] c0, input logic [1:0] c3,
                          input logic [1:0] exp);
    @(negedge clk);
    pin_c0 = c0; pin_c3 = c3;
    repeat (2) @(negedge clk);
    check_flags({req, " early"}, 2'b00);
    @(negedge clk);
    check_flags(req, exp);
    wr(A_CLR, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_flags("R1 reset", 2'b00);
    wr(A_SEL, 8'h0F);
    addr = A_SEL; #1;
    check("R1 sel write-only", rdata, 8'h00);
    wr(A_SEL, 8'h00);

    for (int v = 0; v < NV; v++) begin
      wr(A_SEL, {4'b0, VEC[v][9:6]});
      pulse(VEC[v][5:4], VEC[v][3:2]);
      check_flags($sformatf("R2/R5/R6 vector %0d", v), VEC[v][1:0]);
      wr(A_CLR, 8'hA5);
      check_flags($sformatf("R7 cleared vector %0d", v), 2'b00);
    end

    // R4: mode 10 on req0
    wr(A_SEL, 8'h02);
    set_pins_quiet(2'b00, 2'b00);
    pin_step("R4 rise ignored", 2'b01, 2'b00, 2'b00);
    pin_step("R4 fall sets", 2'b00, 2'b00, 2'b01);

    // R3: mode 01 on req1, R10 latency via pin_step early check
    wr(A_SEL, 8'h04);
    set_pins_quiet(2'b00, 2'b10);
    pin_step("R3 c0 rise with c3 high", 2'b10, 2'b10, 2'b10);
    pin_step("R3 c3 fall with c0 high", 2'b10, 2'b00, 2'b00);
    pin_step("R3 c0 fall", 2'b00, 2'b00, 2'b00);
    pin_step("R3 c3 rise", 2'b00, 2'b10, 2'b00);
    pin_step("R3 c3 fall with c0 low", 2'b00, 2'b00, 2'b10);
    pin_step("R3 c0 rise with c3 low", 2'b10, 2'b00, 2'b00);
    set_pins_quiet(2'b00, 2'b10);
    pin_step("R3 same-cycle rise and fall", 2'b10, 2'b00, 2'b00);
    set_pins_quiet(2'b00, 2'b00);

    // R7: event in the clear cycle wins; wrong address does not clear
    wr(A_SEL, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; addr = A_CLR; cos_evt = 2'b01;
    @(negedge clk);
    wr_en = 1'b0; cos_evt = 2'b00;
    check_flags("R7 event beats clear", 2'b01);
    wr(8'h5C, 8'hFF);
    check_flags("R7 other address keeps", 2'b01);

    // R8: merged events, one clear empties
    pulse(2'b11, 2'b00);
    pulse(2'b11, 2'b00);
    check_flags("R9 both pending", 2'b11);
    wr(A_CLR, 8'h00);
    repeat (2) @(negedge clk);
    check_flags("R8 merged single clear", 2'b00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule